// File: doc/BRIEF.md
# SPI Hold Pause Controller

This block sits between the pins of a serial flash target and its command shifter. It watches chip select, the serial clock and the pause pin, and decides when a pause starts and when it ends. While a pause is active, serial clock edges are not passed to the shifter, the serial input is ignored and the serial data output is disabled, so a host can stop a transfer midway and share the bus for a while.

The pins are sampled on a fast core clock through a configurable synchronizer chain. From these samples the block makes a qualified clock-enable, which is one core cycle long for each counted rising edge of the serial clock. An example shifter with a bit counter uses that enable to assemble words from the serial input. A pause takes effect and ends only while the serial clock is low. When the pause pin changes while the serial clock is high, the change waits until the clock goes low. After a pause, shifting continues from the same bit, so no data is lost. Raising chip select at any time clears the pause and the word in progress.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After reset, with chip select high, `hold_active`, `so_oe`, `clk_en` and `rx_valid` are all 0.
- R2: While `cs_n` is high, no pause can start, even with `hold_n` low, and `so_oe` stays 0.
- R3: With `cs_n` low and `sclk` low, driving `hold_n` low sets `hold_active` to 1.
- R4: If `hold_n` falls while `sclk` is high, `hold_active` stays 0 until `sclk` goes low, and then becomes 1.
- R5: A pause ends only when `hold_n` is high and `sclk` is low. If `hold_n` rises while `sclk` is high, `hold_active` stays 1 until `sclk` goes low.
- R6: `so_oe` is 1 exactly when `cs_n` is low and no pause is active. `so_out` carries `so_data`.
- R7: During a pause, `sclk` rising edges produce no `clk_en` pulse, and `si` has no effect on the word being assembled.
- R8: After a pause ends, shifting continues from the bit position reached before it, so the word completed afterwards equals the bits sent outside the pause.
- R9: Raising `cs_n` during a pause clears `hold_active` and discards the partial word. The next selection starts a new word at bit 0.
- R10: The serial input is captured on each counted `sclk` rising edge, with the first bit as the MSB. After each WORD_W counted edges, `rx_valid` pulses for one cycle with the assembled word on `rx_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples the pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select pin, active low |
| sclk | input | 1 | Serial clock pin |
| hold_n | input | 1 | Pause request pin, active low |
| si | input | 1 | Serial data input pin |
| so_data | input | 1 | Internal serial output data |
| hold_active | output | 1 | A pause is in effect |
| clk_en | output | 1 | One-cycle pulse for each counted sclk rising edge |
| so_oe | output | 1 | Output enable for the serial data output pin |
| so_out | output | 1 | Serial data output value |
| rx_word | output | WORD_W | Last completed word |
| rx_valid | output | 1 | One-cycle pulse when rx_word is updated |

## Verification
Plain words with no pause set the baseline for bit order and word framing. A pause taken with the serial clock low is told apart from one requested while the clock is high, which must wait for the clock to fall. Exits are tested the same two ways. While paused, the bench toggles the serial clock with junk data. Any counted edge or captured bit would then corrupt the word expected after resume, or would raise an extra `rx_valid`. A deselect in the middle of a paused word, followed by a fresh word, shows that the bit position is cleared only by chip select and never by a pause.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
   typedef enum logic {
      PS_RUN   = 1'b0,
      PS_PAUSE = 1'b1
   } pause_state_e;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 4,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_chain
      logic [WIDTH-1:0] stg [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
         end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         end
      end
      assign q = stg[STAGES-1];
   end
endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm
   import spi_hold_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sclk,
   input  logic hold_n,
   output logic paused,
   output logic edge_en
);
   pause_state_e st_q, st_d;
   logic         sclk_d;

   always_comb begin
      st_d = st_q;
      if (cs_n) begin
         st_d = PS_RUN;
      end else begin
         unique case (st_q)
            PS_RUN:   if (!hold_n && !sclk) st_d = PS_PAUSE;
            PS_PAUSE: if (hold_n && !sclk)  st_d = PS_RUN;
            default:  st_d = PS_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= PS_RUN;
         sclk_d <= 1'b0;
      end else begin
         st_q   <= st_d;
         sclk_d <= sclk;
      end
   end

   assign paused  = (st_q == PS_PAUSE);
   assign edge_en = sclk && !sclk_d && !cs_n && !paused;

   // R2
   desel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> !paused);
   // R3
   pause_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !paused && !hold_n && !sclk) |=> paused);
   // R4
   entry_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!paused && sclk) |=> !paused);
   // R5
   exit_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (paused && !cs_n && sclk) |=> paused);
endmodule

// File: rtl/spi_hold_shifter.sv
module spi_hold_shifter
   import spi_hold_pkg::*;
#(
   parameter int unsigned WORD_W    = 8,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              shift_en,
   input  logic              din,
   output logic [WORD_W-1:0] word,
   output logic              word_vld
);
   localparam int unsigned CNT_W = cnt_width(WORD_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   logic [CNT_W-1:0]  cnt_q;
   logic [WORD_W-1:0] sh_q, sh_nxt;

   if (MSB_FIRST) begin : g_msb
      assign sh_nxt = {sh_q[WORD_W-2:0], din};
   end else begin : g_lsb
      assign sh_nxt = {din, sh_q[WORD_W-1:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         sh_q     <= '0;
         word     <= '0;
         word_vld <= 1'b0;
      end else begin
         word_vld <= 1'b0;
         if (clr) begin
            cnt_q <= '0;
            sh_q  <= '0;
         end else if (shift_en) begin
            sh_q <= sh_nxt;
            if (cnt_q == LAST) begin
               cnt_q    <= '0;
               word     <= sh_nxt;
               word_vld <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   // R7
   frozen_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !shift_en) |=> ($stable(cnt_q) && $stable(sh_q)));
   // R10
   vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |=> !word_vld);
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl #(
   parameter int unsigned WORD_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          MSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              hold_n,
   input  logic              si,
   input  logic              so_data,
   output logic              hold_active,
   output logic              clk_en,
   output logic              so_oe,
   output logic              so_out,
   output logic [WORD_W-1:0] rx_word,
   output logic              rx_valid
);
   if (WORD_W < 2) begin : g_bad_width
      $error("spi_hold_ctrl: WORD_W must be at least 2");
   end
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("spi_hold_ctrl: SYNC_STAGES must be 4 or less");
   end

   logic [3:0] pins_raw, pins_s;
   logic       cs_s, sclk_s, hold_s, si_s;
   logic       paused;

   assign pins_raw = {cs_n, sclk, hold_n, si};

   spi_hold_sync #(
      .STAGES  (SYNC_STAGES),
      .WIDTH   (4),
      .RST_VAL (4'b1010)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins_raw),
      .q     (pins_s)
   );

   assign {cs_s, sclk_s, hold_s, si_s} = pins_s;

   spi_hold_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_n    (cs_s),
      .sclk    (sclk_s),
      .hold_n  (hold_s),
      .paused  (paused),
      .edge_en (clk_en)
   );

   spi_hold_shifter #(
      .WORD_W    (WORD_W),
      .MSB_FIRST (MSB_FIRST)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (cs_s),
      .shift_en (clk_en),
      .din      (si_s),
      .word     (rx_word),
      .word_vld (rx_valid)
   );

   assign hold_active = paused;
   assign so_oe       = !cs_s && !paused;
   assign so_out      = so_data;

   // R6
   oe_off_when_paused_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_active) |-> !so_oe);
   // R7
   no_edge_in_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_active && $past(hold_active)) |-> !clk_en);
endmodule

// File: tb/spi_hold_ctrl_tb.sv
module spi_hold_ctrl_tb;
   localparam int unsigned W      = 8;
   localparam int unsigned SETTLE = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sclk = 1'b0, hold_n = 1'b1, si = 1'b0, so_data = 1'b0;
   logic hold_active, clk_en, so_oe, so_out, rx_valid;
   logic [W-1:0] rx_word;

   int checks = 0;
   int fails  = 0;
   int en_cnt = 0;
   bit done   = 1'b0;
   logic [W-1:0] exp_q[$];

   always #2.5 clk = ~clk;

   spi_hold_ctrl #(.WORD_W(W), .SYNC_STAGES(2), .MSB_FIRST(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .hold_n(hold_n),
      .si(si), .so_data(so_data), .hold_active(hold_active), .clk_en(clk_en),
      .so_oe(so_oe), .so_out(so_out), .rx_word(rx_word), .rx_valid(rx_valid)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (SETTLE) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk);
      si = b;
      settle();
      sclk = 1'b1;
      settle();
      sclk = 1'b0;
      settle();
   endtask

   task automatic send_bits(input logic [W-1:0] v, input int from, input int to);
      for (int i = from; i >= to; i--) send_bit(v[i]);
   endtask

   task automatic report();
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   // scoreboard monitor: R10
   always @(negedge clk) begin
      if (rst_n && clk_en) en_cnt++;
      if (rst_n && rx_valid) begin
         if (exp_q.size() == 0) begin
            checks++; fails++;
            $display("FAIL R10 actual=%0h expected=none (unexpected word)", rx_word);
         end else begin
            check("R10 word", rx_word, exp_q.pop_front());
         end
      end
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         report();
      end
   end

   initial begin
      int snap;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();
      // R1
      check("R1 hold_active", hold_active, 0);
      check("R1 so_oe", so_oe, 0);
      check("R1 clk_en", clk_en, 0);
      check("R1 rx_valid", rx_valid, 0);

      // R2: deselected, pause pin low
      hold_n = 1'b0;
      settle();
      check("R2 no pause when deselected", hold_active, 0);
      check("R2 so_oe", so_oe, 0);
      hold_n = 1'b1;

      // R10: plain words
      cs_n = 1'b0;
      settle();
      so_data = 1'b1;
      settle();
      check("R6 so_oe selected", so_oe, 1);
      check("R6 so_out", so_out, 1);
      exp_q.push_back(8'hA5); send_bits(8'hA5, 7, 0);
      exp_q.push_back(8'h3C); send_bits(8'h3C, 7, 0);

      // R3/R7/R8: pause with sclk low in mid-word
      exp_q.push_back(8'hC9);
      send_bits(8'hC9, 7, 5);
      hold_n = 1'b0;
      settle();
      check("R3 entry", hold_active, 1);
      check("R6 so_oe in pause", so_oe, 0);
      snap = en_cnt;
      for (int k = 0; k < 6; k++) send_bit(k[0]);
      check("R7 no edges counted", en_cnt, snap);
      hold_n = 1'b1;
      settle();
      check("R5 exit", hold_active, 0);
      check("R6 so_oe after pause", so_oe, 1);
      send_bits(8'hC9, 4, 0);

      // R4: entry deferred while sclk high
      exp_q.push_back(8'h5E);
      send_bits(8'h5E, 7, 4);
      sclk = 1'b1;
      si = 1'b1;
      settle();
      snap = en_cnt;
      hold_n = 1'b0;
      settle();
      check("R4 entry deferred", hold_active, 0);
      sclk = 1'b0;
      settle();
      check("R4 entry after sclk low", hold_active, 1);
      // junk edge counts: that high phase was a counted bit (1) -> use it
      check("R4 high-phase edge counted before pause", en_cnt, snap);
      // R5: exit deferred while sclk high
      sclk = 1'b1;
      si = 1'b0;
      settle();
      hold_n = 1'b1;
      settle();
      check("R5 exit deferred", hold_active, 1);
      sclk = 1'b0;
      settle();
      check("R5 exit after sclk low", hold_active, 0);
      check("R7 deferred edge not counted", en_cnt, snap);
      // bit 3 of 5E (=1) was sent by the pre-pause high phase; continue at bit 2
      send_bits(8'h5E, 2, 0);

      // R9: deselect during a pause
      send_bits(8'hFF, 7, 5);
      hold_n = 1'b0;
      settle();
      check("R9 paused before deselect", hold_active, 1);
      cs_n = 1'b1;
      settle();
      check("R9 pause cleared", hold_active, 0);
      hold_n = 1'b1;
      cs_n = 1'b0;
      settle();
      exp_q.push_back(8'h81); send_bits(8'h81, 7, 0);
      settle();
      check("R8 queue drained", exp_q.size(), 0);
      cs_n = 1'b1;
      settle();
      check("R2 so_oe deselected", so_oe, 0);
      done = 1'b1;
      report();
   end
endmodule